// File: doc/BRIEF.md
# Scanned Keyboard and Display Controller

This block drives a shared set of scan lines that step through a 64-key matrix and a multiplexed display of up to 16 digits. While a keyboard row is driven, eight active-low return lines are sensed. A low line starts a debounce: the row and line are latched, a programmable interval passes, and the same crossing is checked again the next time its row comes round. Only a key that is still down is encoded into a byte and queued in an eight-entry FIFO. An interrupt stays high while the FIFO holds codes.

The same scan counter selects the display digit. Each display RAM byte goes out as a high nibble and a low nibble on two separate output groups, and a blanking output turns the display dark. The host sees two locations, chosen by one address bit. Location 0 holds key data, and a read pops the FIFO; a write to it stores a display byte. Location 1 returns status on read; a write to it sets the RAM pointer or the blanking state.

Top module: `kbd_disp_ctrl`

## Requirements
- R1: The scan output starts at 0 after reset and advances by one every SCAN_DIV clocks, wrapping after the last value. Its low three bits select the keyboard row.
- R2: In the idle state, a scan step that sees any return line low latches the current row. It also latches the lowest-numbered low line as the column.
- R3: A latched key is accepted only if, after DEB_CYC scan steps and on the next step with its row driven, its return line is still low. A key released earlier leaves no entry.
- R4: The key code is {shift, 0, row[2:0], column[2:0]}: bit 7 is the shift input latched at detection, bit 6 is 0, bits 5:3 are the row and bits 2:0 the column.
- R5: A key held down yields exactly one code. No new detection starts until its crossing is seen released.
- R6: Codes leave the FIFO in arrival order. A data read (a0=0) returns the oldest code and pops it. A data read of an empty FIFO returns 0x00 and leaves the count at 0.
- R7: The status read (a0=1) gives the FIFO count in bits 3:0 and an overrun flag in bit 6; all other bits are 0. A code accepted while the FIFO is full is dropped and sets the overrun flag. A status read clears the flag.
- R8: irq is high exactly while the FIFO count is non-zero.
- R9: A data write stores din into display RAM at the write pointer and advances the pointer, wrapping from 15 to 0. A control write with bit 7 set loads the pointer from din[3:0].
- R10: While scan equals n, disp_hi shows bits 7:4 and disp_lo shows bits 3:0 of RAM entry n.
- R11: A control write with bit 7 clear sets the blanking state to din[0]. While blanked, blank is 1 and both nibble outputs are 0; clearing it restores the RAM contents.
- R12: After reset the FIFO is empty, irq is 0, status reads 0x00, the pointer is 0, blanking is off and all RAM entries are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Host access enable |
| rd | input | 1 | Host read strobe, one cycle per access |
| wr | input | 1 | Host write strobe, one cycle per access |
| a0 | input | 1 | 0 selects data, 1 selects control/status |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data, combinational |
| irq | output | 1 | High while key codes are queued |
| ret_n | input | 8 | Keyboard return lines, active low |
| shift | input | 1 | Shift key level |
| scan | output | $clog2(DIGITS) | Scan counter shared by keyboard and display |
| disp_hi | output | 4 | High nibble of the current digit |
| disp_lo | output | 4 | Low nibble of the current digit |
| blank | output | 1 | Display blanking |

## Verification
Keys are pressed at random rows and columns, with and without shift, through a bench model of the matrix that follows the scan output. Directed cases cover several corner cases. A press that is released just after detection must leave nothing; a design that skipped the re-check would queue a bounce. A key is held for many scan cycles; a design without the release wait would flood the FIFO with repeats. Two keys are pressed in one row, where the wrong priority would report the higher column. A ninth key is pressed into a full FIFO; a wrong design would overwrite the oldest code or lose the overrun flag. The display pointer wraps from 15 to 0, where an off-by-one would show up as a shifted digit.

// File: rtl/kd_pkg.sv
package kd_pkg;
    localparam int KEY_ROWS  = 8;
    localparam int RET_LINES = 8;
    localparam int ROW_W     = $clog2(KEY_ROWS);
    localparam int COL_W     = $clog2(RET_LINES);
    localparam int CODE_W    = 8;

    typedef enum logic [1:0] {
        K_IDLE = 2'd0,
        K_WAIT = 2'd1,
        K_HELD = 2'd2
    } key_st_e;

    function automatic logic [CODE_W-1:0] key_code(input logic sh,
                                                   input logic [ROW_W-1:0] r,
                                                   input logic [COL_W-1:0] c);
        return {sh, 1'b0, r, c};
    endfunction
endpackage

// File: rtl/kd_scan.sv
module kd_scan #(
    parameter int SCAN_DIV = 4,
    parameter int SCAN_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic              tick_o,
    output logic [SCAN_W-1:0] scan_o
);
    localparam int DIV_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCAN_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [SCAN_W-1:0] scan;
    } scan_st_t;

    scan_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        tick_o = (s_q.div == DIV_LAST);
        if (tick_o) begin
            s_d.div  = '0;
            s_d.scan = s_q.scan + 1'b1;
        end else begin
            s_d.div = s_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign scan_o = s_q.scan;

    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (scan_o == SCAN_W'($past(scan_o) + 1'b1))); // R1
    AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick_o |=> $stable(scan_o)); // R1
endmodule

// File: rtl/kd_keydeb.sv
module kd_keydeb
    import kd_pkg::*;
#(
    parameter int DEB_CYC = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic [ROW_W-1:0]     row_i,
    input  logic [RET_LINES-1:0] ret_n_i,
    input  logic                 shift_i,
    output logic                 push_o,
    output logic [CODE_W-1:0]    code_o
);
    localparam int CNT_W = $clog2(DEB_CYC + 1);

    typedef struct packed {
        key_st_e          st;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             sh;
        logic [CNT_W-1:0] cnt;
    } key_t;

    key_t k_d, k_q;
    logic [COL_W-1:0] low_col;
    logic any_low, row_hit, still_down;

    always_comb begin
        low_col = '0;
        for (int i = RET_LINES - 1; i >= 0; i--) begin
            if (!ret_n_i[i]) low_col = COL_W'(i);
        end
        any_low    = ~&ret_n_i;
        row_hit    = (row_i == k_q.row);
        still_down = !ret_n_i[k_q.col];

        k_d    = k_q;
        push_o = 1'b0;
        case (k_q.st)
            K_IDLE: if (tick_i && any_low) begin
                k_d.row = row_i;
                k_d.col = low_col;
                k_d.sh  = shift_i;
                k_d.cnt = CNT_W'(DEB_CYC);
                k_d.st  = K_WAIT;
            end
            K_WAIT: if (tick_i) begin
                if (k_q.cnt != '0) begin
                    k_d.cnt = k_q.cnt - 1'b1;
                end else if (row_hit) begin
                    if (still_down) begin
                        push_o = 1'b1;
                        k_d.st = K_HELD;
                    end else begin
                        k_d.st = K_IDLE;
                    end
                end
            end
            K_HELD: if (tick_i && row_hit && !still_down) k_d.st = K_IDLE;
            default: k_d.st = K_IDLE;
        endcase
        code_o = key_code(k_q.sh, k_q.row, k_q.col);
    end

    always_ff @(posedge clk) begin
        if (rst) k_q <= '0;
        else     k_q <= k_d;
    end

    AST_ACCEPT_STILL_DOWN: assert property (@(posedge clk) disable iff (rst)
        push_o |-> (!ret_n_i[code_o[2:0]] && row_i == code_o[5:3])); // R3
    AST_ONE_PER_PRESS: assert property (@(posedge clk) disable iff (rst)
        push_o |=> !push_o); // R5
endmodule

// File: rtl/kd_fifo.sv
module kd_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push_i,
    input  logic [W-1:0]               data_i,
    input  logic                       pop_i,
    input  logic                       clr_ovr_i,
    output logic [W-1:0]               head_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                       ovr_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rp;
        logic [PTR_W-1:0]        wp;
        logic [CNT_W-1:0]        cnt;
        logic                    ovr;
    } fifo_t;

    fifo_t f_d, f_q;
    logic full, do_push, do_pop;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (f_q.cnt == CNT_W'(DEPTH));
        do_push = push_i && !full;
        do_pop  = pop_i && (f_q.cnt != '0);
        f_d     = f_q;
        if (do_push) begin
            f_d.mem[f_q.wp] = data_i;
            f_d.wp          = nxt(f_q.wp);
        end
        if (do_pop) f_d.rp = nxt(f_q.rp);
        f_d.cnt = f_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        f_d.ovr = (f_q.ovr && !clr_ovr_i) || (push_i && full);
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '0;
        else     f_q <= f_d;
    end

    assign head_o  = (f_q.cnt == '0) ? '0 : f_q.mem[f_q.rp];
    assign count_o = f_q.cnt;
    assign ovr_o   = f_q.ovr;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push_i && full && !pop_i) |=> (count_o == CNT_W'(DEPTH))); // R7
    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        (push_i && full) |=> ovr_o); // R7
    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (pop_i && count_o == '0 && !push_i) |=> (count_o == '0)); // R6
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (push_i && !full && !pop_i) |=> (count_o == CNT_W'($past(count_o) + 1'b1))); // R6
endmodule

// File: rtl/kd_disp.sv
module kd_disp #(
    parameter int DIGITS = 16,
    parameter int SCAN_W = $clog2(DIGITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [7:0]        wdata_i,
    input  logic              set_ptr_i,
    input  logic [SCAN_W-1:0] ptr_i,
    input  logic              set_blank_i,
    input  logic              blank_i,
    input  logic [SCAN_W-1:0] scan_i,
    output logic [3:0]        hi_o,
    output logic [3:0]        lo_o,
    output logic              blank_o
);
    localparam logic [SCAN_W-1:0] PTR_LAST = SCAN_W'(DIGITS - 1);

    typedef struct packed {
        logic [DIGITS-1:0][7:0] ram;
        logic [SCAN_W-1:0]      ptr;
        logic                   blank;
    } disp_t;

    disp_t d_d, d_q;
    logic [7:0] cur;

    always_comb begin
        d_d = d_q;
        if (we_i) begin
            d_d.ram[d_q.ptr] = wdata_i;
            d_d.ptr          = (d_q.ptr == PTR_LAST) ? '0 : d_q.ptr + 1'b1;
        end
        if (set_ptr_i)   d_d.ptr   = ptr_i;
        if (set_blank_i) d_d.blank = blank_i;

        cur = (int'(scan_i) < DIGITS) ? d_q.ram[scan_i] : 8'h00;
        if (d_q.blank) cur = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) d_q <= '0;
        else     d_q <= d_d;
    end

    assign hi_o    = cur[7:4];
    assign lo_o    = cur[3:0];
    assign blank_o = d_q.blank;

    AST_PTR_ADV: assert property (@(posedge clk) disable iff (rst)
        (we_i && !set_ptr_i) |=> (d_q.ptr == (($past(d_q.ptr) == PTR_LAST) ? '0
                                               : SCAN_W'($past(d_q.ptr) + 1'b1)))); // R9
endmodule

// File: rtl/kbd_disp_ctrl.sv
module kbd_disp_ctrl
    import kd_pkg::*;
#(
    parameter int SCAN_DIV   = 1000,
    parameter int DEB_CYC    = 80,
    parameter int DIGITS     = 16,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cs,
    input  logic                       rd,
    input  logic                       wr,
    input  logic                       a0,
    input  logic [7:0]                 din,
    output logic [7:0]                 dout,
    output logic                       irq,
    input  logic [7:0]                 ret_n,
    input  logic                       shift,
    output logic [$clog2(DIGITS)-1:0]  scan,
    output logic [3:0]                 disp_hi,
    output logic [3:0]                 disp_lo,
    output logic                       blank
);
    localparam int SCAN_W = $clog2(DIGITS);
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

    logic              tick_w, push_w, ovr_w;
    logic [CODE_W-1:0] code_w, head_w;
    logic [CNT_W-1:0]  cnt_w;
    logic              wr_dat, wr_ctl, rd_dat, rd_st;
    logic [7:0]        status_w;

    assign wr_dat = cs && wr && !a0;
    assign wr_ctl = cs && wr && a0;
    assign rd_dat = cs && rd && !a0;
    assign rd_st  = cs && rd && a0;

    kd_scan #(.SCAN_DIV(SCAN_DIV), .SCAN_W(SCAN_W)) u_scan (
        .clk(clk), .rst(rst), .tick_o(tick_w), .scan_o(scan)
    );

    kd_keydeb #(.DEB_CYC(DEB_CYC)) u_key (
        .clk(clk), .rst(rst), .tick_i(tick_w), .row_i(scan[ROW_W-1:0]),
        .ret_n_i(ret_n), .shift_i(shift), .push_o(push_w), .code_o(code_w)
    );

    kd_fifo #(.DEPTH(FIFO_DEPTH), .W(CODE_W)) u_fifo (
        .clk(clk), .rst(rst), .push_i(push_w), .data_i(code_w), .pop_i(rd_dat),
        .clr_ovr_i(rd_st), .head_o(head_w), .count_o(cnt_w), .ovr_o(ovr_w)
    );

    kd_disp #(.DIGITS(DIGITS), .SCAN_W(SCAN_W)) u_disp (
        .clk(clk), .rst(rst), .we_i(wr_dat), .wdata_i(din),
        .set_ptr_i(wr_ctl && din[7]), .ptr_i(din[SCAN_W-1:0]),
        .set_blank_i(wr_ctl && !din[7]), .blank_i(din[0]), .scan_i(scan),
        .hi_o(disp_hi), .lo_o(disp_lo), .blank_o(blank)
    );

    always_comb begin
        status_w    = 8'(cnt_w);
        status_w[6] = ovr_w;
        dout        = a0 ? status_w : head_w;
        irq         = (cnt_w != '0);
    end

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(push_w)); // R8
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(rd_dat)); // R8
endmodule

// File: tb/kbd_disp_ctrl_test.sv
module kbd_disp_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int SDIV = 2;
    localparam int DEB  = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic cs = 0, rd = 0, wr = 0, a0 = 0, shift = 0;
    logic [7:0] din = 0, dout, ret_n;
    logic irq, blank;
    logic [3:0] scan, disp_hi, disp_lo;
    logic [7:0] mask [8];
    int checks = 0, fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    kbd_disp_ctrl #(.SCAN_DIV(SDIV), .DEB_CYC(DEB), .DIGITS(16), .FIFO_DEPTH(8)) uut (
        .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .a0(a0), .din(din),
        .dout(dout), .irq(irq), .ret_n(ret_n), .shift(shift), .scan(scan),
        .disp_hi(disp_hi), .disp_lo(disp_lo), .blank(blank)
    );

    assign ret_n = ~mask[scan[2:0]];

    function automatic logic [7:0] exp_code(input logic sh, input int r, input int c);
        return {sh, 1'b0, 3'(r), 3'(c)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic addr, input logic [7:0] d);
        @(negedge clk);
        cs = 1; wr = 1; a0 = addr; din = d;
        @(negedge clk);
        cs = 0; wr = 0;
    endtask

    task automatic host_rd(input logic addr, output logic [7:0] v);
        @(negedge clk);
        cs = 1; rd = 1; a0 = addr;
        #1 v = dout;
        @(negedge clk);
        cs = 0; rd = 0;
    endtask

    task automatic press(input int r, input int c, input logic sh, input int hold);
        shift = sh;
        mask[r][c] = 1'b1;
        repeat (hold) @(negedge clk);
        mask[r] = 8'h00;
        repeat (60) @(negedge clk);
        shift = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v, s0;
        logic [7:0] exp_q [8];
        logic [7:0] ram_m [16];
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 8; i++) mask[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 0;
        // R12 / R1 reset state
        chk("R1 scan at reset", 32'(scan), 0);
        chk("R12 irq at reset", 32'(irq), 0);
        chk("R12 blank at reset", 32'(blank), 0);
        chk("R12 nibbles at reset", {disp_hi, disp_lo}, 0);
        host_rd(1'b1, v);
        chk("R12 status at reset", 32'(v), 0);

        // R1 scan stepping
        for (int k = 0; k < 3; k++) begin
            s0 = 8'(scan);
            while (8'(scan) == s0) @(negedge clk);
            s0 = 8'(scan);
            repeat (SDIV - 1) @(negedge clk);
            chk("R1 scan holds", 32'(scan), 32'(s0));
            @(negedge clk);
            chk("R1 scan steps", 32'(scan), 32'(4'(s0 + 1)));
        end

        // R2 R4 R6 R8: random keys
        for (int i = 0; i < 6; i++) begin
            automatic int r = $urandom_range(0, 7);
            automatic int c = $urandom_range(0, 7);
            automatic logic sh = 1'($urandom_range(0, 1));
            exp_q[i] = exp_code(sh, r, c);
            press(r, c, sh, 120);
        end
        chk("R8 irq with data", 32'(irq), 1);
        host_rd(1'b1, v);
        chk("R7 count after six keys", 32'(v), 6);
        for (int i = 0; i < 6; i++) begin
            host_rd(1'b0, v);
            chk("R4 R6 key code order", 32'(v), 32'(exp_q[i]));
        end
        chk("R8 irq when empty", 32'(irq), 0);

        // R2 lowest column wins
        mask[4] = 8'b0010_0100;
        repeat (120) @(negedge clk);
        mask[4] = 8'h00;
        repeat (60) @(negedge clk);
        host_rd(1'b0, v);
        chk("R2 lowest low line", 32'(v), 32'(exp_code(1'b0, 4, 2)));

        // R3 bounce rejected
        mask[3][6] = 1'b1;
        while (scan[2:0] != 3'd3) @(negedge clk);
        while (scan[2:0] == 3'd3) @(negedge clk);
        mask[3] = 8'h00;
        repeat (100) @(negedge clk);
        host_rd(1'b1, v);
        chk("R3 bounce leaves nothing", 32'(v), 0);

        // R5 long hold gives one code
        press(6, 1, 1'b0, 500);
        host_rd(1'b1, v);
        chk("R5 held key one entry", 32'(v), 1);
        host_rd(1'b0, v);
        chk("R5 held key code", 32'(v), 32'(exp_code(1'b0, 6, 1)));

        // R7 overrun
        for (int k = 0; k < 9; k++) press(k % 8, (k * 3) % 8, 1'b0, 120);
        host_rd(1'b1, v);
        chk("R7 full with overrun", 32'(v), 32'h48);
        for (int k = 0; k < 8; k++) begin
            host_rd(1'b0, v);
            chk("R7 kept codes", 32'(v), 32'(exp_code(1'b0, k % 8, (k * 3) % 8)));
        end
        host_rd(1'b1, v);
        chk("R7 overrun cleared, ninth dropped", 32'(v), 0);
        host_rd(1'b0, v);
        chk("R6 empty read value", 32'(v), 0);
        host_rd(1'b1, v);
        chk("R6 empty read count", 32'(v), 0);

        // R9 R10 display RAM
        host_wr(1'b1, 8'h80);
        for (int d = 0; d < 16; d++) begin
            ram_m[d] = 8'($urandom);
            host_wr(1'b0, ram_m[d]);
        end
        ram_m[0] = 8'hA5;
        host_wr(1'b0, 8'hA5);
        host_wr(1'b1, 8'h85);
        ram_m[5] = 8'h3C;
        host_wr(1'b0, 8'h3C);
        for (int d = 0; d < 16; d++) begin
            while (scan != 4'(d)) @(negedge clk);
            chk("R9 R10 digit nibbles", {disp_hi, disp_lo}, 32'(ram_m[d]));
        end

        // R11 blanking
        host_wr(1'b1, 8'h01);
        chk("R11 blank on", 32'(blank), 1);
        for (int d = 0; d < 4; d++) begin
            while (scan != 4'(d)) @(negedge clk);
            chk("R11 dark while blanked", {disp_hi, disp_lo}, 0);
        end
        host_wr(1'b1, 8'h00);
        while (scan != 4'd5) @(negedge clk);
        chk("R11 restored after unblank", {disp_hi, disp_lo}, 32'(ram_m[5]));
        chk("R11 blank off", 32'(blank), 0);

        finish_run();
    end
endmodule